// File: doc/BRIEF.md
# Exception Cause Priority Selector

This block sits where one instruction's accumulated exception flags are turned into a single trap cause. It takes a 24-bit flag vector, one bit for each cause number, and reports the one cause that wins. Next to that cause it gives a valid bit and the filtered flag vector that the selection was made from. The block is purely combinational, so the answer appears in the same cycle as the flags.

A mode input picks the filter. In all-causes mode, every defined cause position passes and the unused positions are cleared. In frontend mode, only the causes that the fetch and decode stages can raise pass. The winner is then chosen by a fixed ranking that does not follow numeric order. The breakpoint ranks highest. Among fetch faults, the page fault beats the guest-page fault, which beats the access fault. Store faults beat load faults, and access faults come last.

Top module: `exc_cause_select`

## Requirements
- R1: With `front_only` low, `exc_masked` equals `exc_flags` AND 24'hF0BFFF, which is the defined causes 0 to 13, 15 and 20 to 23.
- R2: With `front_only` high, `exc_masked` equals `exc_flags` AND 24'h501007, which is causes 0, 1, 2, 12, 20 and 22. Every other position reads zero.
- R3: `exc_valid` is high exactly when `exc_masked` has at least one bit set.
- R4: When `exc_valid` is low, `exc_cause` is zero.
- R5: When several filtered bits are set, `exc_cause` is the one ranked highest in the order 3, 12, 20, 1, 2, 22, 0, 11, 9, 10, 8, 6, 4, 15, 13, 23, 21, 7, 5. The bit at that cause position of `exc_masked` is set.
- R6: A single raised flag that passes the active filter is reported as its own cause number, with `exc_valid` high.
- R7: Flags raised only at undefined positions (14, 16, 17, 18, 19) give `exc_valid` low and `exc_cause` zero in either mode.
- R8: In frontend mode, a raised flag that is not a frontend cause, such as the breakpoint (3), does not hide a raised frontend cause of lower rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exc_flags | input | 24 | Raised exception flags, with bit index equal to the cause number |
| front_only | input | 1 | 1 = pass only frontend causes, 0 = pass all defined causes |
| exc_valid | output | 1 | At least one filtered flag is set |
| exc_cause | output | 5 | Cause number of the winning flag, or 0 when none |
| exc_masked | output | 24 | Flag vector after the mode filter |

## Verification
The checker tests its properties every time the inputs change. The filtered vector must stay inside the mask of the active mode and must be a subset of the raised flags. The valid bit must match a non-empty filtered vector. The cause must be zero when valid is low, and when valid is high the reported cause's bit must be set. The checker cannot see whether the winner is the right one among several raised flags. Only the bench's reference ranking can show that, so the bench runs every single-hot position in both modes, random multi-hot vectors, and the case where a breakpoint is hidden in frontend mode.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;

    localparam int VEC_W      = 24;
    localparam int CAUSE_W    = 5;
    localparam int NUM_RANKED = 19;

    // Positions that carry an architected cause.
    localparam logic [VEC_W-1:0] DEFINED_MASK = 24'hF0BFFF;
    // Causes detected before the instruction leaves decode.
    localparam logic [VEC_W-1:0] FRONT_MASK   = 24'h501007;

    typedef enum logic {
        SEL_ALL   = 1'b0,
        SEL_FRONT = 1'b1
    } sel_mode_e;

    // Rank 0 is the highest priority; returns the cause number at that rank.
    function automatic int rank_to_cause(input int rank);
        int c;
        unique case (rank)
            0:  c = 3;
            1:  c = 12;
            2:  c = 20;
            3:  c = 1;
            4:  c = 2;
            5:  c = 22;
            6:  c = 0;
            7:  c = 11;
            8:  c = 9;
            9:  c = 10;
            10: c = 8;
            11: c = 6;
            12: c = 4;
            13: c = 15;
            14: c = 13;
            15: c = 23;
            16: c = 21;
            17: c = 7;
            default: c = 5;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/exc_mask_unit.sv
module exc_mask_unit
    import exc_sel_pkg::*;
#(
    parameter int W = VEC_W
) (
    input  logic [W-1:0] flags_in,
    input  sel_mode_e    mode,
    output logic [W-1:0] flags_out
);

    localparam logic [W-1:0] ALL_M   = W'(DEFINED_MASK);
    localparam logic [W-1:0] FRONT_M = W'(FRONT_MASK);

    logic [W-1:0] keep;

    always_comb begin
        unique case (mode)
            SEL_FRONT: keep = FRONT_M;
            default:   keep = ALL_M;
        endcase
    end

    assign flags_out = flags_in & keep;

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
    import exc_sel_pkg::*;
#(
    parameter int W      = VEC_W,
    parameter int RANKED = NUM_RANKED
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant
);

    logic [RANKED:0]   seen;
    logic [RANKED-1:0] win_at_rank;

    assign seen[0] = 1'b0;

    for (genvar k = 0; k < RANKED; k++) begin : g_rank
        localparam int C = rank_to_cause(k);
        assign win_at_rank[k] = req[C] & ~seen[k];
        assign seen[k+1]      = seen[k] | req[C];
    end

    always_comb begin
        grant = '0;
        for (int k = 0; k < RANKED; k++) begin
            grant[rank_to_cause(k)] = grant[rank_to_cause(k)] | win_at_rank[k];
        end
    end

endmodule

// File: rtl/exc_cause_enc.sv
module exc_cause_enc #(
    parameter int W  = 24,
    parameter int CW = 5
) (
    input  logic [W-1:0]  onehot,
    output logic [CW-1:0] code
);

    always_comb begin
        code = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot[i]) code = code | CW'(i);
        end
    end

endmodule

// File: rtl/exc_cause_select.sv
module exc_cause_select
    import exc_sel_pkg::*;
#(
    parameter int W  = VEC_W,
    parameter int CW = CAUSE_W
) (
    input  logic [W-1:0]  exc_flags,
    input  logic          front_only,
    output logic          exc_valid,
    output logic [CW-1:0] exc_cause,
    output logic [W-1:0]  exc_masked
);

    sel_mode_e    mode;
    logic [W-1:0] filtered;
    logic [W-1:0] grant;

    assign mode = front_only ? SEL_FRONT : SEL_ALL;

    exc_mask_unit #(.W(W)) u_mask (
        .flags_in  (exc_flags),
        .mode      (mode),
        .flags_out (filtered)
    );

    exc_prio_pick #(.W(W), .RANKED(NUM_RANKED)) u_pick (
        .req   (filtered),
        .grant (grant)
    );

    exc_cause_enc #(.W(W), .CW(CW)) u_enc (
        .onehot (grant),
        .code   (exc_cause)
    );

    assign exc_valid  = |filtered;
    assign exc_masked = filtered;

endmodule

// File: rtl/exc_cause_select_chk.sv
module exc_cause_select_chk
    import exc_sel_pkg::*;
#(
    parameter int W  = VEC_W,
    parameter int CW = CAUSE_W
) (
    input logic [W-1:0]  exc_flags,
    input logic          front_only,
    input logic          exc_valid,
    input logic [CW-1:0] exc_cause,
    input logic [W-1:0]  exc_masked
);

    always_comb begin
        // R1: filtered vector stays inside the raised flags and defined positions
        p_masked_subset_r1: assert ((exc_masked & ~(exc_flags & W'(DEFINED_MASK))) == '0)
            else $error("masked vector outside flags/defined set");
        // R2: frontend mode lets nothing outside the frontend set through
        p_front_filter_r2: assert (!front_only || ((exc_masked & ~W'(FRONT_MASK)) == '0))
            else $error("non-frontend cause passed in frontend mode");
        // R3: valid tracks a non-empty filtered vector
        p_valid_any_r3: assert (exc_valid == (exc_masked != '0))
            else $error("valid disagrees with masked vector");
        // R4: no cause reported without valid
        p_cause_idle_r4: assert (exc_valid || (exc_cause == '0))
            else $error("cause nonzero while not valid");
        // R5: the reported cause is one of the filtered raised flags
        p_cause_raised_r5: assert (!exc_valid || ((int'(exc_cause) < W) && exc_masked[exc_cause]))
            else $error("reported cause not raised");
    end

endmodule

bind exc_cause_select exc_cause_select_chk #(.W(W), .CW(CW)) u_chk (
    .exc_flags  (exc_flags),
    .front_only (front_only),
    .exc_valid  (exc_valid),
    .exc_cause  (exc_cause),
    .exc_masked (exc_masked)
);

// File: tb/exc_cause_select_test.sv
`timescale 1ns/1ps
module exc_cause_select_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] flags = '0;
    logic        fmode = 1'b0;
    logic        valid;
    logic [4:0]  cause;
    logic [23:0] masked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int prio[$] = '{3, 12, 20, 1, 2, 22, 0, 11, 9, 10, 8, 6, 4, 15, 13, 23, 21, 7, 5};
    int front_set[$] = '{0, 1, 2, 12, 20, 22};
    int undef_set[$] = '{14, 16, 17, 18, 19};

    always #4 clk = ~clk;

    exc_cause_select uut (
        .exc_flags  (flags),
        .front_only (fmode),
        .exc_valid  (valid),
        .exc_cause  (cause),
        .exc_masked (masked)
    );

    function automatic bit in_list(int v, int lst[$]);
        foreach (lst[i]) if (lst[i] == v) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [23:0] ref_mask(logic [23:0] f, logic m);
        logic [23:0] r = '0;
        for (int i = 0; i < 24; i++) begin
            if (m) r[i] = f[i] && in_list(i, front_set);
            else   r[i] = f[i] && in_list(i, prio);
        end
        return r;
    endfunction

    task automatic check(string req);
        logic [23:0] em;
        logic [4:0]  ec;
        logic        ev;
        em = ref_mask(flags, fmode);
        ev = (em != '0);
        ec = '0;
        foreach (prio[k]) begin
            if (em[prio[k]]) begin
                ec = 5'(prio[k]);
                break;
            end
        end
        checks++;
        if (valid !== ev || cause !== ec || masked !== em) begin
            fails++;
            $display("FAIL %s flags=%h mode=%0d: valid=%0d cause=%0d masked=%h expected valid=%0d cause=%0d masked=%h",
                     req, flags, fmode, valid, cause, masked, ev, ec, em);
        end
    endtask

    task automatic apply(logic [23:0] f, logic m, string req);
        @(posedge clk);
        flags = f;
        fmode = m;
        @(negedge clk);
        check(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R4");                                 // idle: nothing raised
        apply(24'h000000, 1'b1, "R3");
        // single-hot sweep in both modes
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 24; p++) begin
                if (in_list(p, undef_set))                   apply(24'(1) << p, m[0], "R7");
                else if (m == 1 && !in_list(p, front_set))   apply(24'(1) << p, m[0], "R2");
                else                                         apply(24'(1) << p, m[0], "R6");
            end
        end
        apply(24'hFFFFFF, 1'b0, "R1");               // expect cause 3
        apply(24'hFFFFFF, 1'b1, "R2");               // expect cause 12
        apply(24'h0F4000, 1'b0, "R7");
        apply(24'h0F4000, 1'b1, "R7");
        apply(24'h000009, 1'b1, "R8");               // breakpoint hidden, cause 0
        apply(24'h500008, 1'b1, "R8");               // expect cause 20
        apply(24'h0000A0, 1'b0, "R5");               // store access 7 over load access 5
        apply(24'h00A000, 1'b0, "R5");               // store page 15 over load page 13
        apply(24'h100002, 1'b0, "R5");               // guest page 20 over access 1
        apply(24'h000F00, 1'b0, "R5");               // ecall M 11 first
        for (int n = 0; n < 400; n++) begin
            apply(24'($urandom), n[0], "R5");
        end
        for (int n = 0; n < 100; n++) begin
            apply(24'($urandom) & 24'($urandom) & 24'($urandom), n[0], "R5");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule